// File: doc/BRIEF.md
# Parallel NOR Flash Identification Prober

This block identifies a parallel NOR flash part sitting on a simple word-addressed bus with separate write and read strobes. A single-cycle start pulse launches a fixed run. The run writes the three-step unlock and autoselect command, reads back a manufacturer byte and a device word, and classifies the pair into a vendor class and a geometry record. The geometry record holds the sector count, the total size in KiB and the boot-sector arrangement. The run then writes a read-array command so the part leaves identification mode.

Every bus access holds its strobe for a programmable number of cycles. Consecutive accesses are separated by idle cycles. Writes to the part are fenced by a write-disable flag, which drops only while a run is in progress. The classification appears on output registers. A one-cycle done pulse marks the end of each run, and the classification stays valid until the next run decodes a new pair.

Top module: `nor_id_prober`

## Requirements
- R1: After an accepted start, the first three bus accesses are writes, in this order: 0xAA to word address UNLOCK1_ADDR (default 0x554), 0x55 to UNLOCK2_ADDR (default 0x2AB), then 0x90 to UNLOCK1_ADDR. Command bytes are zero-extended to the data width.
- R2: The fourth access is a read of word address 1, and the fifth is a read of word address 0. The manufacturer code is bits [7:0] of the word-1 read; any upper bits are ignored. The device code is the full word-0 read.
- R3: A recognised pair gives a vendor class, a sector count, a size and a layout, from this list:
  - 0xC2/0x22A8: class 3, 71 sectors, 4096 KiB, layout 2.
  - 0xC2/0x2249: class 3, 35 sectors, 2048 KiB, layout 3.
  - 0xC2/0x22CB: class 3, 135 sectors, 8192 KiB, layout 2.
  - 0x01/0x22D7: class 1, 128 sectors, 8192 KiB, layout 1.
  - 0x89/0x8896: class 2, 32 sectors, 4096 KiB, layout 1.
  - 0x89/0x88C4: class 2, 71 sectors, 4096 KiB, layout 2.

  Layout codes are: 1 uniform; 2 eight 8 KiB sectors at the bottom; 3 bottom sectors of 16, 8, 8 and 32 KiB.
- R4: Any other pair, including a known manufacturer with a device code listed for a different manufacturer, gives class 0 (unknown), sector count 0, size 0 and layout 0.
- R5: The sixth and last access writes to word address 0. It writes 0xFF when the manufacturer code is 0x89, and 0xF0 for every other code, unknown ones included.
- R6: wr_disable_o is 1 out of reset and while idle. It is 0 from the cycle after a start is accepted until the cycle after the last write completes. The write strobe is never high while wr_disable_o is 1.
- R7: Each strobe stays high for exactly W+1 cycles, where W is wait_cfg_i sampled at the accepted start. The two strobes are never high together, and a strobe never rises in the cycle after either strobe was high.
- R8: A start pulse while busy_o is 1 is ignored: no extra accesses, no change of the captured wait count, and a single done pulse for the run.
- R9: done_o is high for exactly one cycle per run, with busy_o already 0. The classification outputs are valid at that cycle and hold until the next run's decode.
- R10: During and right after reset, both strobes, busy_o and done_o are 0, wr_disable_o is 1, and the classification outputs are 0.
- R11: Address and write data are stable for the whole time a strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, used only while idle |
| wait_cfg_i | input | WAIT_W | Extra strobe cycles per access, sampled at start |
| bus_addr_o | output | ADDR_W | Flash word address |
| bus_wdata_o | output | DATA_W | Flash write data |
| bus_rdata_i | input | DATA_W | Flash read data |
| bus_we_o | output | 1 | Write strobe |
| bus_re_o | output | 1 | Read strobe |
| wr_disable_o | output | 1 | Write fence, high when no run is active |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| vendor_o | output | 2 | Vendor class: 0 unknown, 1/3 unlock-cycle style, 2 status-register style |
| sector_cnt_o | output | 8 | Sector count |
| size_kib_o | output | 16 | Total size in KiB |
| boot_layout_o | output | 2 | Boot-sector arrangement code |
| mfr_code_o | output | 8 | Captured manufacturer byte |
| dev_code_o | output | DATA_W | Captured device word |

## Verification
The assertions assume that bus_rdata_i is settled by the last cycle of a read strobe. They also assume that start_i and wait_cfg_i change only between clock edges, and that reset is applied at time zero before any start. The bench flash model answers combinationally from the strobed address and switches between identification and array data only on write strobes. Inputs are always driven on the falling edge. Some runs change wait_cfg_i and pulse start_i again while the prober is busy, and the bench checks that the strobe width still follows the value captured at the accepted start.

// File: rtl/nor_id_pkg.sv
package nor_id_pkg;

  localparam int SECT_W    = 8;
  localparam int SIZE_W    = 16;
  localparam int NUM_PARTS = 6;

  typedef enum logic [1:0] {
    VEND_NONE     = 2'd0,
    VEND_UNLOCK_A = 2'd1,
    VEND_STATUS   = 2'd2,
    VEND_UNLOCK_B = 2'd3
  } vendor_e;

  typedef enum logic [1:0] {
    LAY_NONE      = 2'd0,
    LAY_UNIFORM   = 2'd1,
    LAY_BOT8      = 2'd2,
    LAY_BOT_MIXED = 2'd3
  } layout_e;

  typedef struct packed {
    vendor_e             vendor;
    logic [SECT_W-1:0]   sectors;
    logic [SIZE_W-1:0]   size_kib;
    layout_e             layout;
  } geom_t;

  typedef struct packed {
    logic [7:0]  mfr;
    logic [15:0] dev;
    geom_t       geom;
  } part_t;

  localparam logic [7:0] MFR_STATUS    = 8'h89;
  localparam logic [7:0] CMD_UNLOCK1   = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK2   = 8'h55;
  localparam logic [7:0] CMD_AUTOSEL   = 8'h90;
  localparam logic [7:0] CMD_RD_STATUS = 8'hFF;
  localparam logic [7:0] CMD_RD_UNLOCK = 8'hF0;

  localparam part_t PART_TAB [NUM_PARTS] = '{
    '{8'hC2, 16'h22A8, '{VEND_UNLOCK_B, 8'd71,  16'd4096, LAY_BOT8}},
    '{8'hC2, 16'h2249, '{VEND_UNLOCK_B, 8'd35,  16'd2048, LAY_BOT_MIXED}},
    '{8'hC2, 16'h22CB, '{VEND_UNLOCK_B, 8'd135, 16'd8192, LAY_BOT8}},
    '{8'h01, 16'h22D7, '{VEND_UNLOCK_A, 8'd128, 16'd8192, LAY_UNIFORM}},
    '{8'h89, 16'h8896, '{VEND_STATUS,   8'd32,  16'd4096, LAY_UNIFORM}},
    '{8'h89, 16'h88C4, '{VEND_STATUS,   8'd71,  16'd4096, LAY_BOT8}}
  };

  typedef enum logic [3:0] {
    S_IDLE   = 4'd0,
    S_UNL1   = 4'd1,
    S_UNL2   = 4'd2,
    S_AUTO   = 4'd3,
    S_RD_MFR = 4'd4,
    S_RD_DEV = 4'd5,
    S_DECODE = 4'd6,
    S_EXIT   = 4'd7
  } prb_state_e;

endpackage

// File: rtl/nor_bus_seq.sv
module nor_bus_seq #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              idle_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_we_o,
  output logic              bus_re_o
);

  typedef enum logic [1:0] {B_IDLE, B_ACT, B_GAP} bstate_e;

  bstate_e           st_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= B_IDLE;
      cnt_q   <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        B_IDLE: if (req_i) begin
          st_q    <= B_ACT;
          cnt_q   <= '0;
          we_q    <= req_we_i;
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
        end
        B_ACT: if (cnt_q == wait_i) begin
          st_q <= B_GAP;
          if (!we_q) rdata_q <= bus_rdata_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        B_GAP:   st_q <= B_IDLE;
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign idle_o      = (st_q == B_IDLE);
  assign ack_o       = (st_q == B_GAP);
  assign rdata_o     = rdata_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign bus_we_o    = (st_q == B_ACT) &&  we_q;
  assign bus_re_o    = (st_q == B_ACT) && !we_q;

endmodule

// File: rtl/nor_id_classify.sv
module nor_id_classify
  import nor_id_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [7:0]        mfr_i,
  input  logic [DATA_W-1:0] dev_i,
  output geom_t             geom_o,
  output logic [7:0]        exit_cmd_o
);

  logic [NUM_PARTS-1:0] hit;

  for (genvar g = 0; g < NUM_PARTS; g++) begin : g_match
    assign hit[g] = (mfr_i == PART_TAB[g].mfr) &&
                    (dev_i == DATA_W'(PART_TAB[g].dev));
  end

  always_comb begin
    geom_o = '0;
    for (int i = 0; i < NUM_PARTS; i++) begin
      if (hit[i]) geom_o = PART_TAB[i].geom;
    end
  end

  // exit command follows the manufacturer, even when the pair is unknown
  assign exit_cmd_o = (mfr_i == MFR_STATUS) ? CMD_RD_STATUS : CMD_RD_UNLOCK;

endmodule

// File: rtl/nor_id_prober.sv
module nor_id_prober
  import nor_id_pkg::*;
#(
  parameter int              ADDR_W       = 20,
  parameter int              DATA_W       = 16,
  parameter int              WAIT_W       = 4,
  parameter logic [ADDR_W-1:0] UNLOCK1_ADDR = ADDR_W'(12'h554),
  parameter logic [ADDR_W-1:0] UNLOCK2_ADDR = ADDR_W'(12'h2AB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_we_o,
  output logic              bus_re_o,
  output logic              wr_disable_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        vendor_o,
  output logic [SECT_W-1:0] sector_cnt_o,
  output logic [SIZE_W-1:0] size_kib_o,
  output logic [1:0]        boot_layout_o,
  output logic [7:0]        mfr_code_o,
  output logic [DATA_W-1:0] dev_code_o
);

  prb_state_e        state_q;
  logic [WAIT_W-1:0] wait_q;
  logic [7:0]        mfr_q;
  logic [DATA_W-1:0] dev_q;
  geom_t             geom_q;
  logic [7:0]        exit_cmd_q;
  logic              done_q;
  logic              wr_dis_q;

  logic              acc_go, acc_we;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] acc_data;
  logic              seq_idle, seq_ack;
  logic [DATA_W-1:0] seq_rdata;
  geom_t             cls_geom;
  logic [7:0]        cls_cmd;

  always_comb begin
    acc_go   = 1'b0;
    acc_we   = 1'b0;
    acc_addr = '0;
    acc_data = '0;
    case (state_q)
      S_UNL1: begin
        acc_go = 1'b1; acc_we = 1'b1;
        acc_addr = UNLOCK1_ADDR; acc_data = DATA_W'(CMD_UNLOCK1);
      end
      S_UNL2: begin
        acc_go = 1'b1; acc_we = 1'b1;
        acc_addr = UNLOCK2_ADDR; acc_data = DATA_W'(CMD_UNLOCK2);
      end
      S_AUTO: begin
        acc_go = 1'b1; acc_we = 1'b1;
        acc_addr = UNLOCK1_ADDR; acc_data = DATA_W'(CMD_AUTOSEL);
      end
      S_RD_MFR: begin
        acc_go = 1'b1; acc_addr = ADDR_W'(1);
      end
      S_RD_DEV: begin
        acc_go = 1'b1; acc_addr = '0;
      end
      S_EXIT: begin
        acc_go = 1'b1; acc_we = 1'b1;
        acc_addr = '0; acc_data = DATA_W'(exit_cmd_q);
      end
      default: ;
    endcase
  end

  nor_bus_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (acc_go && seq_idle),
    .req_we_i   (acc_we),
    .req_addr_i (acc_addr),
    .req_wdata_i(acc_data),
    .wait_i     (wait_q),
    .idle_o     (seq_idle),
    .ack_o      (seq_ack),
    .rdata_o    (seq_rdata),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i),
    .bus_we_o   (bus_we_o),
    .bus_re_o   (bus_re_o)
  );

  nor_id_classify #(.DATA_W(DATA_W)) u_cls (
    .mfr_i     (mfr_q),
    .dev_i     (dev_q),
    .geom_o    (cls_geom),
    .exit_cmd_o(cls_cmd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      wait_q     <= '0;
      mfr_q      <= '0;
      dev_q      <= '0;
      geom_q     <= '0;
      exit_cmd_q <= '0;
      done_q     <= 1'b0;
      wr_dis_q   <= 1'b1;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q  <= S_UNL1;
          wait_q   <= wait_cfg_i;
          wr_dis_q <= 1'b0;
        end
        S_UNL1: if (seq_ack) state_q <= S_UNL2;
        S_UNL2: if (seq_ack) state_q <= S_AUTO;
        S_AUTO: if (seq_ack) state_q <= S_RD_MFR;
        S_RD_MFR: if (seq_ack) begin
          mfr_q   <= seq_rdata[7:0];
          state_q <= S_RD_DEV;
        end
        S_RD_DEV: if (seq_ack) begin
          dev_q   <= seq_rdata;
          state_q <= S_DECODE;
        end
        S_DECODE: begin
          geom_q     <= cls_geom;
          exit_cmd_q <= cls_cmd;
          state_q    <= S_EXIT;
        end
        S_EXIT: if (seq_ack) begin
          state_q  <= S_IDLE;
          done_q   <= 1'b1;
          wr_dis_q <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign wr_disable_o  = wr_dis_q;
  assign busy_o        = (state_q != S_IDLE);
  assign done_o        = done_q;
  assign vendor_o      = geom_q.vendor;
  assign sector_cnt_o  = geom_q.sectors;
  assign size_kib_o    = geom_q.size_kib;
  assign boot_layout_o = geom_q.layout;
  assign mfr_code_o    = mfr_q;
  assign dev_code_o    = dev_q;

endmodule

// File: rtl/nor_id_prober_chk.sv
module nor_id_prober_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic              bus_re_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              wr_disable_i,
  input logic              busy_i,
  input logic              done_i,
  input logic [1:0]        vendor_i,
  input logic [7:0]        sector_cnt_i,
  input logic [15:0]       size_kib_i,
  input logic [1:0]        boot_layout_i,
  input logic [WAIT_W-1:0] wait_q_i
);

  logic            strobe;
  logic [WAIT_W:0] hi_cnt;

  assign strobe = bus_we_i | bus_re_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_cnt <= '0;
    else if (strobe) hi_cnt <= hi_cnt + 1'b1;
    else             hi_cnt <= '0;
  end

  assert_no_dual_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_re_i));

  assert_gap_after_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_we_i) |-> !bus_re_i);

  assert_gap_after_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_re_i) |-> !bus_we_i);

  assert_strobe_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe) |-> (hi_cnt == ({1'b0, wait_q_i} + 1'b1)));

  assert_write_fence_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i |-> !wr_disable_i);

  assert_bus_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe && $past(strobe)) |-> ($stable(bus_addr_i) && $stable(bus_wdata_i)));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!busy_i && wr_disable_i));

  assert_unknown_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vendor_i == 2'd0) |-> (sector_cnt_i == 8'd0 && size_kib_i == 16'd0 && boot_layout_i == 2'd0));

  assert_wait_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_i) && busy_i) |-> $stable(wait_q_i));

endmodule

bind nor_id_prober nor_id_prober_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_we_i     (bus_we_o),
  .bus_re_i     (bus_re_o),
  .bus_addr_i   (bus_addr_o),
  .bus_wdata_i  (bus_wdata_o),
  .wr_disable_i (wr_disable_o),
  .busy_i       (busy_o),
  .done_i       (done_o),
  .vendor_i     (vendor_o),
  .sector_cnt_i (sector_cnt_o),
  .size_kib_i   (size_kib_o),
  .boot_layout_i(boot_layout_o),
  .wait_q_i     (wait_q)
);

// File: tb/nor_id_prober_test.sv
`timescale 1ns/1ps
module nor_id_prober_test;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int WAIT_W = 4;
  localparam logic [ADDR_W-1:0] U1 = 20'h554;
  localparam logic [ADDR_W-1:0] U2 = 20'h2AB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [WAIT_W-1:0] wait_cfg = '0;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;
  logic we, re, wr_dis, busy, done;
  logic [1:0] vendor, layout;
  logic [7:0] sect, mfr_out;
  logic [15:0] size_kib;
  logic [DATA_W-1:0] dev_out;

  always #2 clk = ~clk;

  nor_id_prober uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wait_cfg_i(wait_cfg),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_rdata_i(rdata),
    .bus_we_o(we), .bus_re_o(re), .wr_disable_o(wr_dis), .busy_o(busy),
    .done_o(done), .vendor_o(vendor), .sector_cnt_o(sect), .size_kib_o(size_kib),
    .boot_layout_o(layout), .mfr_code_o(mfr_out), .dev_code_o(dev_out)
  );

  // flash model
  logic [15:0] m_mfr_word = 16'h0000;
  logic [15:0] m_dev = 16'h0000;
  logic id_mode = 1'b0;
  int unl_st = 0;
  assign rdata = !id_mode ? 16'hFFFF :
                 (addr == 20'd1) ? m_mfr_word :
                 (addr == 20'd0) ? m_dev : 16'h0000;

  // monitor
  logic acc_we [256];
  logic [ADDR_W-1:0] acc_addr [256];
  logic [DATA_W-1:0] acc_data [256];
  int n_acc = 0, hi = 0, gap = 100, exp_wait = 0;
  int width_err = 0, gap_err = 0, stab_err = 0, prot_err = 0, done_cnt = 0, dbl_err = 0;
  logic p_strobe = 1'b0, p_done = 1'b0;
  logic [ADDR_W-1:0] a_addr;
  logic [DATA_W-1:0] a_data;

  always @(negedge clk) begin
    if (rst_n) begin
      if ((we || re) && !p_strobe) begin
        if (gap < 1) gap_err++;
        acc_we[n_acc % 256] = we;
        acc_addr[n_acc % 256] = addr;
        acc_data[n_acc % 256] = wdata;
        n_acc++;
        hi = 1; a_addr = addr; a_data = wdata;
        if (we) begin
          if (wdata == 16'h00AA && addr == U1) unl_st = 1;
          else if (unl_st == 1 && wdata == 16'h0055 && addr == U2) unl_st = 2;
          else if (unl_st == 2 && wdata == 16'h0090 && addr == U1) begin id_mode = 1'b1; unl_st = 0; end
          else begin
            if (wdata == 16'h00F0 || wdata == 16'h00FF) id_mode = 1'b0;
            unl_st = 0;
          end
        end
      end else if (we || re) begin
        hi++;
        if (addr != a_addr || wdata != a_data) stab_err++;
      end
      if (!(we || re) && p_strobe && hi != exp_wait + 1) width_err++;
      if (we || re) gap = 0; else gap++;
      if (we && wr_dis) prot_err++;
      if (done) begin done_cnt++; if (p_done) dbl_err++; end
      p_strobe = we || re;
      p_done = done;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    check(!we && !re, "R10 strobes", {30'd0, we, re}, 0);
    check(!busy && !done, "R10 busy/done", {30'd0, busy, done}, 0);
    check(wr_dis, "R10 wr_disable", wr_dis, 1);
    check(vendor == 0 && sect == 0 && size_kib == 0 && layout == 0, "R10 geometry",
          {vendor, sect, size_kib, layout}, 0);
  endtask

  task automatic t_probe(input logic [15:0] mfr_word, input logic [15:0] dev, input int wt,
                         input int e_v, input int e_s, input int e_k, input int e_l,
                         input int e_cmd, input string tag, input bit extra_start);
    int base, d0, we0, ge0, se0, pe0, de0, cyc;
    base = n_acc; d0 = done_cnt; we0 = width_err; ge0 = gap_err;
    se0 = stab_err; pe0 = prot_err; de0 = dbl_err;
    m_mfr_word = mfr_word; m_dev = dev; exp_wait = wt;
    @(negedge clk); wait_cfg = WAIT_W'(wt); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy && !wr_dis, "R6 active after start", {30'd0, busy, wr_dis}, 2);
    if (extra_start) begin
      repeat (5) @(negedge clk);
      wait_cfg = WAIT_W'(wt + 3); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 1000) begin @(negedge clk); cyc++; end
    check(done, "R9 done seen", done, 1);
    check(!busy && wr_dis, "R9 done while idle", {30'd0, busy, wr_dis}, 1);
    check(vendor == e_v, {tag, " vendor"}, vendor, e_v);
    check(sect == e_s, {tag, " sectors"}, sect, e_s);
    check(size_kib == e_k, {tag, " size"}, size_kib, e_k);
    check(layout == e_l, {tag, " layout"}, layout, e_l);
    check(mfr_out == mfr_word[7:0], "R2 mfr low byte", mfr_out, mfr_word[7:0]);
    check(dev_out == dev, "R2 device word", dev_out, dev);
    check(n_acc - base == 6, extra_start ? "R8 access count" : "R1 access count", n_acc - base, 6);
    check(acc_we[(base) % 256] && acc_addr[(base) % 256] == U1 && acc_data[(base) % 256] == 16'h00AA,
          "R1 step 1", acc_data[(base) % 256], 16'h00AA);
    check(acc_we[(base+1) % 256] && acc_addr[(base+1) % 256] == U2 && acc_data[(base+1) % 256] == 16'h0055,
          "R1 step 2", acc_data[(base+1) % 256], 16'h0055);
    check(acc_we[(base+2) % 256] && acc_addr[(base+2) % 256] == U1 && acc_data[(base+2) % 256] == 16'h0090,
          "R1 step 3", acc_data[(base+2) % 256], 16'h0090);
    check(!acc_we[(base+3) % 256] && acc_addr[(base+3) % 256] == 20'd1, "R2 read word 1",
          acc_addr[(base+3) % 256], 1);
    check(!acc_we[(base+4) % 256] && acc_addr[(base+4) % 256] == 20'd0, "R2 read word 0",
          acc_addr[(base+4) % 256], 0);
    check(acc_we[(base+5) % 256] && acc_addr[(base+5) % 256] == 20'd0 && acc_data[(base+5) % 256] == e_cmd,
          "R5 exit command", acc_data[(base+5) % 256], e_cmd);
    check(width_err == we0, "R7 strobe width", width_err - we0, 0);
    check(gap_err == ge0, "R7 strobe gap", gap_err - ge0, 0);
    check(stab_err == se0, "R11 bus stable", stab_err - se0, 0);
    check(prot_err == pe0, "R6 write fence", prot_err - pe0, 0);
    @(negedge clk);
    check(!done, "R9 single pulse", done, 0);
    check(!id_mode, "R5 model back in array mode", id_mode, 0);
    repeat (3) @(negedge clk);
    check(vendor == e_v && sect == e_s && size_kib == e_k && layout == e_l, "R9 result held",
          {vendor, sect, size_kib, layout}, {e_v[1:0], e_s[7:0], e_k[15:0], e_l[1:0]});
    check(done_cnt - d0 == 1 && dbl_err == de0, extra_start ? "R8 one done" : "R9 one done",
          done_cnt - d0, 1);
    check(n_acc - base == 6 && !busy, "R8 no restart", n_acc - base, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_probe(16'h77C2, 16'h22A8, 0, 3, 71,  4096, 2, 16'h00F0, "R3", 0);
    t_probe(16'h00C2, 16'h2249, 2, 3, 35,  2048, 3, 16'h00F0, "R3", 0);
    t_probe(16'h5A89, 16'h8896, 1, 2, 32,  4096, 1, 16'h00FF, "R3", 0);
    t_probe(16'h0001, 16'h22D7, 3, 1, 128, 8192, 1, 16'h00F0, "R3", 0);
    t_probe(16'h00C2, 16'h22CB, 5, 3, 135, 8192, 2, 16'h00F0, "R3", 0);
    t_probe(16'h0089, 16'h88C4, 0, 2, 71,  4096, 2, 16'h00FF, "R3", 0);
    t_probe(16'h001F, 16'h22A8, 2, 0, 0, 0, 0, 16'h00F0, "R4", 0);
    t_probe(16'h0089, 16'h22A8, 1, 0, 0, 0, 0, 16'h00FF, "R4", 0);
    t_probe(16'hC201, 16'h22D7, 4, 1, 128, 8192, 1, 16'h00F0, "R3", 1);
    t_probe(16'h00C2, 16'h0000, 15, 0, 0, 0, 0, 16'h00F0, "R4", 0);
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule